// File: doc/BRIEF.md
# Interprocessor Interrupt Command Register

This block is a memory-mapped 64-bit command register that is split into two 32-bit words, together with the logic that turns a software write into one outgoing interprocessor message. Software first writes the target word, which holds an 8-bit destination. It then writes the command word. The write to the command word latches every field and presents a message on a valid/ready output port.

A pending flag in the command word reads back as 1 from the launch until the port accepts the message. Software polls this flag before it issues the next command. While the flag is set, further command-word writes are dropped. When the shorthand field is non-zero it takes the place of the destination, and the message then carries an all-ones destination.

Top module: `ipi_cmd_reg`

## Requirements
- R1: After reset `msg_valid` is 0, and reads of the command word (offset 0x300) and of the target word (offset 0x310) both return 0.
- R2: A write to offset 0x310 stores bits 31:24 as the destination. A read of 0x310 returns that destination in bits 31:24, with bits 23:0 reading 0.
- R3: A write to offset 0x300 while idle raises `msg_valid` on the next cycle. The message latches vector = bits 7:0, kind = bits 10:8, logical = bit 11, assert = bit 14, level-trigger = bit 15 and shorthand = bits 19:18.
- R4: A read of 0x300 returns the latched fields at the same bit positions and the pending flag in bit 12. Bits 13, 17:16 and 31:20 read 0. Values written to bit 12 and to those reserved bits have no effect.
- R5: While `msg_valid` is 1 and `msg_ready` is 0, all message fields hold steady. On the cycle after `msg_valid && msg_ready`, `msg_valid` and bit 12 read 0, and the latched fields remain readable.
- R6: A write to 0x300 while the message is pending is ignored. This includes a write in the same cycle as the accepting handshake.
- R7: With shorthand 00, `msg_dest` is the destination stored at launch. With any other shorthand, `msg_dest` is all ones.
- R8: A write to 0x310 while a message is pending changes the readback of 0x310 but not the `msg_dest` of the message in flight.
- R9: Writes to any other offset have no effect, and reads of any other offset return 0.
- R10: Command word 0x000C4500 launches kind 101, assert 1, edge trigger (0), physical mode and shorthand 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Word offset within the register window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| msg_valid | output | 1 | Message present / pending |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_vector | output | 8 | Interrupt vector |
| msg_kind | output | 3 | Delivery kind |
| msg_logical | output | 1 | Logical destination mode |
| msg_assert | output | 1 | Level: 1 assert, 0 de-assert |
| msg_level_trig | output | 1 | Trigger: 1 level, 0 edge |
| msg_shorthand | output | 2 | Destination shorthand |
| msg_dest | output | DEST_W | Effective destination |

## Verification
The hazard that matters is a command-word write that lands in the same cycle as the handshake that retires the pending message. In that cycle the block is still pending, so the write must be dropped. The bench provokes this case on every fourth sweep point by raising `msg_ready` and the write strobe on the same edge. It then confirms that `msg_valid` falls and that the command-word readback still shows the old fields. A target-word write during the pending window is also mixed in, and the bench judges it by comparing `msg_dest` with the 0x310 readback.

// File: rtl/ipi_cmd_pkg.sv
package ipi_cmd_pkg;

    typedef struct packed {
        logic [7:0] vector;
        logic [2:0] kind;
        logic       logical;
        logic       assert_lvl;
        logic       level_trig;
        logic [1:0] shorthand;
    } cmd_t;

    localparam int VEC_LSB   = 0;
    localparam int KIND_LSB  = 8;
    localparam int LOGIC_BIT = 11;
    localparam int PEND_BIT  = 12;
    localparam int ASRT_BIT  = 14;
    localparam int TRIG_BIT  = 15;
    localparam int SH_LSB    = 18;

    function automatic cmd_t word_to_cmd(input logic [31:0] w);
        cmd_t c;
        c.vector     = w[VEC_LSB +: 8];
        c.kind       = w[KIND_LSB +: 3];
        c.logical    = w[LOGIC_BIT];
        c.assert_lvl = w[ASRT_BIT];
        c.level_trig = w[TRIG_BIT];
        c.shorthand  = w[SH_LSB +: 2];
        return c;
    endfunction

    function automatic logic [31:0] cmd_to_word(input cmd_t c, input logic pend);
        logic [31:0] w;
        w = '0;
        w[VEC_LSB +: 8]  = c.vector;
        w[KIND_LSB +: 3] = c.kind;
        w[LOGIC_BIT]     = c.logical;
        w[PEND_BIT]      = pend;
        w[ASRT_BIT]      = c.assert_lvl;
        w[TRIG_BIT]      = c.level_trig;
        w[SH_LSB +: 2]   = c.shorthand;
        return w;
    endfunction

endpackage

// File: rtl/ipi_target_reg.sv
module ipi_target_reg #(
    parameter int ADDR_W   = 12,
    parameter int LOW_OFS  = 'h300,
    parameter int HIGH_OFS = 'h310,
    parameter int DEST_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [31:0]          bus_wdata,
    input  logic [31:0]          cmd_word,
    output logic                 lo_wr,
    output logic [DEST_W-1:0]    dest_q,
    output logic [31:0]          bus_rdata
);
    localparam int DEST_LSB = 32 - DEST_W;
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LOW_OFS);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HIGH_OFS);

    typedef struct packed {
        logic [DEST_W-1:0] dest;
    } st_t;

    st_t st_d, st_q;
    logic hi_wr;

    always_comb begin
        st_d      = st_q;
        lo_wr     = bus_wr && (bus_addr == LO_A);
        hi_wr     = bus_wr && (bus_addr == HI_A);
        if (hi_wr) st_d.dest = bus_wdata[DEST_LSB +: DEST_W];
        bus_rdata = '0;
        if (bus_addr == LO_A)      bus_rdata = cmd_word;
        else if (bus_addr == HI_A) bus_rdata[DEST_LSB +: DEST_W] = st_q.dest;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dest_q = st_q.dest;

    // R2
    hi_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr |=> (dest_q == $past(bus_wdata[DEST_LSB +: DEST_W])));
endmodule

// File: rtl/ipi_launch.sv
module ipi_launch
    import ipi_cmd_pkg::*;
#(
    parameter int DEST_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lo_wr,
    input  logic [31:0]          wdata,
    input  logic [DEST_W-1:0]    dest_in,
    input  logic                 msg_ready,
    output logic                 pend,
    output cmd_t                 cmd,
    output logic [DEST_W-1:0]    dest_out
);
    typedef struct packed {
        logic              pend;
        cmd_t              cmd;
        logic [DEST_W-1:0] dest;
    } st_t;

    st_t st_d, st_q;
    cmd_t nc;

    always_comb begin
        st_d = st_q;
        nc   = word_to_cmd(wdata);
        if (st_q.pend && msg_ready) st_d.pend = 1'b0;
        if (lo_wr && !st_q.pend) begin
            st_d.pend = 1'b1;
            st_d.cmd  = nc;
            st_d.dest = (nc.shorthand == 2'b00) ? dest_in : {DEST_W{1'b1}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend     = st_q.pend;
    assign cmd      = st_q.cmd;
    assign dest_out = st_q.dest;

    // R6
    ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && lo_wr) |=> $stable(cmd) && $stable(dest_out));
endmodule

// File: rtl/ipi_cmd_reg.sv
module ipi_cmd_reg
    import ipi_cmd_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int LOW_OFS  = 'h300,
    parameter int HIGH_OFS = 'h310,
    parameter int DEST_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 msg_valid,
    input  logic                 msg_ready,
    output logic [7:0]           msg_vector,
    output logic [2:0]           msg_kind,
    output logic                 msg_logical,
    output logic                 msg_assert,
    output logic                 msg_level_trig,
    output logic [1:0]           msg_shorthand,
    output logic [DEST_W-1:0]    msg_dest
);
    logic              lo_wr;
    logic [DEST_W-1:0] dest_q;
    logic              pend;
    cmd_t              cmd;
    logic [31:0]       cmd_word;

    assign cmd_word = cmd_to_word(cmd, pend);

    ipi_target_reg #(
        .ADDR_W(ADDR_W), .LOW_OFS(LOW_OFS), .HIGH_OFS(HIGH_OFS), .DEST_W(DEST_W)
    ) u_tgt (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .cmd_word(cmd_word), .lo_wr(lo_wr),
        .dest_q(dest_q), .bus_rdata(bus_rdata)
    );

    ipi_launch #(.DEST_W(DEST_W)) u_launch (
        .clk(clk), .rst_n(rst_n), .lo_wr(lo_wr), .wdata(bus_wdata),
        .dest_in(dest_q), .msg_ready(msg_ready), .pend(pend), .cmd(cmd),
        .dest_out(msg_dest)
    );

    assign msg_valid      = pend;
    assign msg_vector     = cmd.vector;
    assign msg_kind       = cmd.kind;
    assign msg_logical    = cmd.logical;
    assign msg_assert     = cmd.assert_lvl;
    assign msg_level_trig = cmd.level_trig;
    assign msg_shorthand  = cmd.shorthand;

    // R3
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(LOW_OFS) && !msg_valid) |=>
            msg_valid && msg_vector == $past(bus_wdata[7:0]));
    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=>
            msg_valid && $stable(msg_vector) && $stable(msg_kind) && $stable(msg_dest));
    // R5
    retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready) |=> !msg_valid);
    // R7
    shorthand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_shorthand != 2'b00) |-> (msg_dest == {DEST_W{1'b1}}));
endmodule

// File: tb/sim_ipi_cmd_reg.sv
module sim_ipi_cmd_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        msg_valid, msg_ready = 1'b0;
    logic [7:0]  msg_vector;
    logic [2:0]  msg_kind;
    logic        msg_logical, msg_assert, msg_level_trig;
    logic [1:0]  msg_shorthand;
    logic [7:0]  msg_dest;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ipi_cmd_reg u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_kind(msg_kind),
        .msg_logical(msg_logical), .msg_assert(msg_assert),
        .msg_level_trig(msg_level_trig), .msg_shorthand(msg_shorthand),
        .msg_dest(msg_dest)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] mk(input logic [7:0] v, input logic [2:0] k,
            input logic lg, input logic p, input logic as, input logic tr, input logic [1:0] sh);
        return {12'h0, sh, 2'b00, tr, as, 1'b0, p, lg, k, v};
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, exp_lo;
        logic [7:0]  dst, edst, vec;
        logic [2:0]  k;
        logic [1:0]  sh;
        logic        lg, as, tr;
        #9 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid", msg_valid, 0);
        rd(12'h300, r); chk("R1 lo", r, 0);
        rd(12'h310, r); chk("R1 hi", r, 0);

        for (int i = 0; i < 256; i++) begin
            k = i[2:0]; sh = i[4:3]; lg = i[5]; as = i[6]; tr = i[7];
            vec = 8'((i * 37 + 5) & 255);
            dst = 8'((i * 13 + 1) & 255);
            wr(12'h310, {dst, 24'hABCDEF});
            rd(12'h310, r); chk("R2 hi readback", r, {dst, 24'h0});
            wr(12'h300, mk(vec, k, lg, 1'b0, as, tr, sh) | 32'hFFF3_3000);
            edst = (sh == 2'b00) ? dst : 8'hFF;
            exp_lo = mk(vec, k, lg, 1'b1, as, tr, sh);
            chk("R3 valid", msg_valid, 1);
            chk("R3 fields", {msg_vector, msg_kind, msg_logical, msg_assert, msg_level_trig, msg_shorthand},
                {vec, k, lg, as, tr, sh});
            chk("R7 dest", msg_dest, edst);
            rd(12'h300, r); chk("R4 lo readback", r, exp_lo);
            for (int d = 0; d < i % 3; d++) @(negedge clk);
            if (i % 2 == 1) begin
                wr(12'h300, mk(~vec, ~k, ~lg, 1'b0, ~as, ~tr, ~sh));
                rd(12'h300, r); chk("R6 ignored while pending", r, exp_lo);
                wr(12'h310, {dst ^ 8'h5A, 24'h0});
                rd(12'h310, r); chk("R8 hi readback", r, {dst ^ 8'h5A, 24'h0});
                chk("R8 dest in flight", msg_dest, edst);
            end
            chk("R5 held", {msg_valid, msg_vector, msg_dest}, {1'b1, vec, edst});
            @(negedge clk);
            msg_ready = 1'b1;
            if (i % 4 == 0) begin
                bus_addr = 12'h300; bus_wdata = mk(~vec, k, lg, 1'b0, as, tr, 2'b00); bus_wr = 1'b1;
            end
            @(negedge clk);
            msg_ready = 1'b0; bus_wr = 1'b0;
            chk("R5 retired", msg_valid, 0);
            rd(12'h300, r);
            chk(i % 4 == 0 ? "R6 same-cycle write dropped" : "R5 status clear", r, exp_lo & ~32'h1000);
        end

        wr(12'h304, 32'hFFFF_FFFF);
        rd(12'h304, r); chk("R9 other read", r, 0);
        chk("R9 no launch", msg_valid, 0);
        wr(12'h300, 32'h000C_4500);
        chk("R10 fields", {msg_valid, msg_kind, msg_assert, msg_level_trig, msg_logical, msg_shorthand},
            {1'b1, 3'b101, 1'b1, 1'b0, 1'b0, 2'b11});
        chk("R10 dest", msg_dest, 8'hFF);
        @(negedge clk); msg_ready = 1'b1;
        @(negedge clk); msg_ready = 1'b0;
        chk("R5 final retire", msg_valid, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule